// File: doc/BRIEF.md
# Pulse-and-verify programming controller

This controller burns a byte image into a one-time-programmable array whose cells can only move from 1 to 0. After a start request it walks the target from address zero upward. For each location it fetches the intended byte from an image store and reads what the cell holds now. It then applies fixed-width program pulses, and after every pulse it reads the byte back. It moves on only once the readback matches.

Each location has its own pulse budget. A byte that has not taken after the last allowed pulse ends the run as a failure. A byte that would need a 0-to-1 change cannot be fixed by pulsing, so the run stops at once without a pulse. When every byte has taken, the controller drops the program-level supply flag and reads the whole array again under normal-read conditions. It reports success only if every byte matches. The end of a run is a one-cycle done strobe that carries the pass flag.

Top module: `pv_prog_ctrl`

## Requirements
- R1: After synchronous reset `done`, `prog_strobe`, `tgt_rd` and `vpp_hi` are all 0, and the controller waits for `start`.
- R2: Each program pulse holds `prog_strobe` high for exactly PULSE_CYC consecutive cycles.
- R3: Between two pulses on the same address the controller issues a verify read (`tgt_rd`) of that address.
- R4: A byte that takes on its k-th pulse, with k no greater than MAX_PULSES (25 by default), receives exactly k pulses.
- R5: If a byte still reads wrong after MAX_PULSES pulses, the run ends with `pass`=0 and no further pulse or address is issued.
- R6: Pulsed addresses are non-decreasing from address 0, and `tgt_addr` stays stable while a pulse is in progress.
- R7: A byte whose current content already equals the image gets no pulse. A byte whose image value has a 1 where the cell holds 0 ends the run with `pass`=0 and no pulse.
- R8: After the last address, every location is read with `vpp_hi`=0 and compared with the image in address order; the first mismatch ends the run with `pass`=0.
- R9: `done` is high for exactly one cycle per run. `pass`=1 only if programming and the full compare both succeed.
- R10: The pulse count restarts at each new address, so the total number of pulses across bytes is not limited.
- R11: `vpp_hi` is 1 in every cycle in which `prog_strobe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a run |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Result, valid with `done` |
| img_rd | output | 1 | Image store read enable |
| img_addr | output | ADDR_W | Image store address |
| img_rdata | input | DATA_W | Image byte, one cycle after `img_rd` |
| tgt_addr | output | ADDR_W | Target array address |
| tgt_wdata | output | DATA_W | Byte being programmed |
| prog_strobe | output | 1 | Program pulse to the target |
| tgt_rd | output | 1 | Target read enable |
| tgt_rdata | input | DATA_W | Target read data, one cycle after `tgt_rd` |
| vpp_hi | output | 1 | 1 = program-level conditions, 0 = normal-read conditions |

## Verification
Two decisions can fall due in the same evaluation cycle. The first is when a byte's verify succeeds on exactly the last allowed pulse, so the success and the budget-exhausted decision coincide. The second is when the last address verifies, so the step to the next byte and the switch into the compare pass coincide. The bench places a byte that needs exactly 25 pulses, and one that needs 26, against random images. It expects a pass in the first case and a failure with exactly 25 pulses in the second. It also checks that the count of reads taken with `vpp_hi` low equals the number of locations up to the first mismatch it injects in the compare pass.

// File: rtl/pv_pkg.sv
package pv_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_P_FETCH,
    ST_P_LOAD,
    ST_P_PULSE,
    ST_P_VRD,
    ST_P_VEV,
    ST_C_FETCH,
    ST_C_EV
  } pv_state_e;
endpackage

// File: rtl/pv_pulse_timer.sv
module pv_pulse_timer #(
  parameter int PULSE_CYC = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic last_o
);
  localparam int TW = $clog2(PULSE_CYC + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else if (last_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = run_i && (cnt_q == TW'(PULSE_CYC - 1));

  a_r2_pulse_starts_fresh: assert property (@(posedge clk) disable iff (rst)
    $rose(run_i) |-> (cnt_q == '0));
endmodule

// File: rtl/pv_attempt_ctr.sv
module pv_attempt_ctr #(
  parameter int MAX_PULSES = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic exhausted_o
);
  localparam int CW = $clog2(MAX_PULSES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign exhausted_o = (cnt_q == CW'(MAX_PULSES));

  // R5: no pulse may start once the budget is spent
  a_r5_budget_respected: assert property (@(posedge clk) disable iff (rst)
    inc_i |-> (cnt_q < CW'(MAX_PULSES)));
endmodule

// File: rtl/pv_prog_ctrl.sv
module pv_prog_ctrl
  import pv_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int PULSE_CYC  = 5000,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              done,
  output logic              pass,
  output logic              img_rd,
  output logic [ADDR_W-1:0] img_addr,
  input  logic [DATA_W-1:0] img_rdata,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_wdata,
  output logic              prog_strobe,
  output logic              tgt_rd,
  input  logic [DATA_W-1:0] tgt_rdata,
  output logic              vpp_hi
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  pv_state_e         st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] want_q;
  logic              done_q, pass_q;
  logic              pulse_last, exhausted, att_clr, att_inc;
  logic              needs_raise;

  pv_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk(clk), .rst(rst), .run_i(st_q == ST_P_PULSE), .last_o(pulse_last)
  );

  assign att_clr = (st_q == ST_P_LOAD);
  assign att_inc = pulse_last;

  pv_attempt_ctr #(.MAX_PULSES(MAX_PULSES)) u_att (
    .clk(clk), .rst(rst), .clr_i(att_clr), .inc_i(att_inc),
    .exhausted_o(exhausted)
  );

  assign needs_raise = |(img_rdata & ~tgt_rdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      want_q <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          addr_q <= '0;
          pass_q <= 1'b0;
          st_q   <= ST_P_FETCH;
        end
        ST_P_FETCH: st_q <= ST_P_LOAD;
        ST_P_LOAD: begin
          want_q <= img_rdata;
          if (tgt_rdata == img_rdata) begin
            if (addr_q == LAST_ADDR) begin
              addr_q <= '0;
              st_q   <= ST_C_FETCH;
            end else begin
              addr_q <= addr_q + 1'b1;
              st_q   <= ST_P_FETCH;
            end
          end else if (needs_raise) begin
            done_q <= 1'b1;
            pass_q <= 1'b0;
            st_q   <= ST_IDLE;
          end else begin
            st_q <= ST_P_PULSE;
          end
        end
        ST_P_PULSE: if (pulse_last) st_q <= ST_P_VRD;
        ST_P_VRD:   st_q <= ST_P_VEV;
        ST_P_VEV: begin
          if (tgt_rdata == want_q) begin
            if (addr_q == LAST_ADDR) begin
              addr_q <= '0;
              st_q   <= ST_C_FETCH;
            end else begin
              addr_q <= addr_q + 1'b1;
              st_q   <= ST_P_FETCH;
            end
          end else if (exhausted) begin
            done_q <= 1'b1;
            pass_q <= 1'b0;
            st_q   <= ST_IDLE;
          end else begin
            st_q <= ST_P_PULSE;
          end
        end
        ST_C_FETCH: st_q <= ST_C_EV;
        ST_C_EV: begin
          if (tgt_rdata != img_rdata) begin
            done_q <= 1'b1;
            pass_q <= 1'b0;
            st_q   <= ST_IDLE;
          end else if (addr_q == LAST_ADDR) begin
            done_q <= 1'b1;
            pass_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            addr_q <= addr_q + 1'b1;
            st_q   <= ST_C_FETCH;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done        = done_q;
  assign pass        = pass_q;
  assign img_addr    = addr_q;
  assign tgt_addr    = addr_q;
  assign tgt_wdata   = want_q;
  assign img_rd      = (st_q == ST_P_FETCH) || (st_q == ST_C_FETCH);
  assign tgt_rd      = img_rd || (st_q == ST_P_VRD);
  assign prog_strobe = (st_q == ST_P_PULSE);
  assign vpp_hi      = (st_q == ST_P_FETCH) || (st_q == ST_P_LOAD) ||
                       (st_q == ST_P_PULSE) || (st_q == ST_P_VRD) ||
                       (st_q == ST_P_VEV);

  a_r11_pulse_at_prog_level: assert property (@(posedge clk) disable iff (rst)
    prog_strobe |-> vpp_hi);
  a_r3_no_read_while_pulsing: assert property (@(posedge clk) disable iff (rst)
    !(prog_strobe && tgt_rd));
  a_r6_addr_held_in_pulse: assert property (@(posedge clk) disable iff (rst)
    (prog_strobe && $past(prog_strobe)) |-> $stable(tgt_addr));
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_raise_aborts: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_P_LOAD) && (tgt_rdata != img_rdata) && needs_raise)
      |=> (done && !pass && !prog_strobe));
endmodule

// File: tb/sim_pv_prog_ctrl.sv
module sim_pv_prog_ctrl;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int D  = 1 << AW;
  localparam int PC = 4;
  localparam int MP = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic done, pass, img_rd, prog_strobe, tgt_rd, vpp_hi;
  logic [AW-1:0] img_addr, tgt_addr;
  logic [DW-1:0] img_rdata, tgt_wdata, tgt_rdata;

  always #2.5 clk = ~clk;

  pv_prog_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PC), .MAX_PULSES(MP)) u0 (
    .clk(clk), .rst(rst), .start(start), .done(done), .pass(pass),
    .img_rd(img_rd), .img_addr(img_addr), .img_rdata(img_rdata),
    .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .prog_strobe(prog_strobe),
    .tgt_rd(tgt_rd), .tgt_rdata(tgt_rdata), .vpp_hi(vpp_hi)
  );

  logic [DW-1:0] mem [D];
  logic [DW-1:0] img [D];
  int need [D];
  int pulses [D];
  int exp_p [D];
  int marg = -1;
  int run = 0, rd_since = 0, last_pa = 0, low_reads = 0;
  int err_r2 = 0, err_r3 = 0, err_r6 = 0, err_r11 = 0;
  int n_chk = 0, n_fail = 0;

  // behavioural target array and image store
  always @(posedge clk) begin
    if (prog_strobe) begin
      if (!vpp_hi) err_r11++;
      if (run == 0) begin
        if (pulses[tgt_addr] > 0 && rd_since == 0) err_r3++;
        if (int'(tgt_addr) < last_pa) err_r6++;
        last_pa  = int'(tgt_addr);
        rd_since = 0;
      end
      run++;
      if (run == PC) begin
        pulses[tgt_addr]++;
        if (pulses[tgt_addr] >= need[tgt_addr]) mem[tgt_addr] = mem[tgt_addr] & tgt_wdata;
        run = 0;
      end
    end else if (run != 0) begin
      err_r2++;
      run = 0;
    end
    if (tgt_rd) begin
      rd_since = 1;
      if (!vpp_hi) low_reads++;
      tgt_rdata <= (marg == int'(tgt_addr) && !vpp_hi) ? (mem[tgt_addr] ^ 8'h01) : mem[tgt_addr];
    end
    img_rdata <= img[img_addr];
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setup_random(input int maxneed);
    for (int a = 0; a < D; a++) begin
      mem[a]  = 8'hFF;
      img[a]  = 8'($urandom);
      need[a] = 1 + int'($urandom % maxneed);
    end
    marg = -1;
  endtask

  task automatic run_case(input string nm);
    int exp_pass, fail_at, exp_low, seen;
    logic [DW-1:0] m0;
    exp_pass = 1; fail_at = -1;
    for (int a = 0; a < D; a++) exp_p[a] = 0;
    for (int a = 0; a < D; a++) begin
      m0 = mem[a];
      if (img[a] == m0) continue;
      if ((img[a] & ~m0) != 0) begin exp_pass = 0; fail_at = a; break; end
      if (need[a] > MP) begin exp_p[a] = MP; exp_pass = 0; fail_at = a; break; end
      exp_p[a] = need[a];
    end
    exp_low = (fail_at >= 0) ? 0 : ((marg >= 0) ? marg + 1 : D);
    if (fail_at < 0 && marg >= 0) exp_pass = 0;
    for (int a = 0; a < D; a++) pulses[a] = 0;
    err_r2 = 0; err_r3 = 0; err_r6 = 0; err_r11 = 0; low_reads = 0; last_pa = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    seen = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen == 1, "R9", {nm, " done seen"}, seen, 1);
    chk(int'(pass) == exp_pass, "R9", {nm, " pass (R5 R7 R8)"}, int'(pass), exp_pass);
    @(negedge clk);
    chk(done == 1'b0, "R9", {nm, " done one cycle"}, int'(done), 0);
    for (int a = 0; a < D; a++)
      chk(pulses[a] == exp_p[a], "R4", $sformatf("%s pulses@%0d (R10 R5 R7)", nm, a), pulses[a], exp_p[a]);
    chk(low_reads == exp_low, "R8", {nm, " normal-read compares"}, low_reads, exp_low);
    chk(err_r2 == 0, "R2", {nm, " pulse width errors"}, err_r2, 0);
    chk(err_r3 == 0, "R3", {nm, " pulse without verify"}, err_r3, 0);
    chk(err_r6 == 0, "R6", {nm, " address order"}, err_r6, 0);
    chk(err_r11 == 0, "R11", {nm, " pulse below program level"}, err_r11, 0);
  endtask

  initial begin
    int s;
    s = int'($urandom(32'h5EED_0042));
    for (int a = 0; a < D; a++) begin mem[a] = 8'hFF; img[a] = 8'hFF; need[a] = 1; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    chk(done == 0 && prog_strobe == 0 && tgt_rd == 0 && vpp_hi == 0, "R1", "idle outputs",
        int'({done, prog_strobe, tgt_rd, vpp_hi}), 0);

    setup_random(MP);
    need[2] = MP; img[2] = 8'h00;       // R4 boundary: takes on the last allowed pulse
    img[7] = 8'hFF;                     // R7: already matches, no pulse
    run_case("rand_boundary25");

    setup_random(MP);
    need[5] = MP + 1; img[5] = 8'h3C;   // R5: never takes within budget
    run_case("budget_exhausted");

    setup_random(MP);
    mem[3] = 8'h0F; img[3] = 8'hF0;     // R7: needs a 0-to-1 change
    run_case("raise_needed");

    setup_random(MP);
    for (int a = 0; a < D; a++) if (img[a] == 8'hFF) img[a] = 8'hFE;
    marg = 9;                           // R8: differs only under normal-read
    run_case("compare_mismatch");

    setup_random(MP);
    marg = D - 1;                       // R8: mismatch on the last compare
    run_case("compare_last");

    setup_random(MP);
    for (int a = 0; a < D; a++) begin img[a] = 8'h00; need[a] = MP; end
    run_case("all_max_R10");

    for (int r = 0; r < 3; r++) begin
      setup_random(MP);
      run_case($sformatf("rand_%0d", r));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule